// File: doc/BRIEF.md
# Trace capture arm/stop controller

This block decides when a debug trace memory records samples. Before capture is enabled, software sets three 3-bit fields. The first picks the event that arms recording. The second picks the event that ends it. The third picks which of six candidate source buses supplies the samples. The block watches a set of one-cycle event pulses (watchpoint hit, trace-match hit, performance-counter overflow), an asynchronous external trigger level, and a pair of context identifiers. Once armed, it streams every valid sample from the chosen bus into a circular memory through a write port.

Recording moves through four phases: off, waiting for the arming event, recording, and stopped. A stop request counts only after the block has armed. "Memory full" is one of the selectable reasons to stop. Stopped is a terminal phase: only dropping the enable leaves it. The trace memory and the comparators that produce the event pulses are outside the block.

Top module: `trc_capture_ctrl`

## Requirements
- R1: While reset is asserted, and from the cycle after `cap_en` is seen low, `wr_en`, `st_armed`, `st_trig`, `st_stopped` and `st_err` are 0 and the write address restarts at 0.
- R2: With arm code 000, `st_armed` is 1 from the second rising edge after `cap_en` is first seen high. No event is needed.
- R3: Arm codes 001, 010 and 011 arm on the edge that samples `ev_watch`, `ev_match` and `ev_perf` high, respectively.
- R4: Arm code 100 arms on a rising edge of `ext_trig`, and code 101 arms on a falling edge. The level passes through two synchronizer flops and an edge register, so the block arms on the third rising clock edge after the level change is first sampled. Each level change gives exactly one event.
- R5: Arm code 110 arms when `ctx_cur` equals `ctx_prog`. Arm code 111 arms when they differ.
- R6: While recording, each cycle in which the selected source's valid bit is 1 gives `wr_en`=1, with that source's data on `wr_data`. `wr_addr` then advances by one, modulo 2^AW. Source code 000, 001 and 010 select slots 0, 1 and 2. Codes 100, 101 and 110 select slots 3, 4 and 5. Slot i occupies bits [i*DW +: DW] of `src_data` and bit i of `src_valid`.
- R7: Source codes 011 and 111 are reserved. With one of them latched, `st_err` is 1 while enabled and nothing is ever written.
- R8: Stop code 000 ends recording once 2^AW samples have been written. No further sample is written.
- R9: Stop codes 001 to 111 use the same events as the arm codes. The cycle in which the stop event is seen writes nothing, and `st_stopped` is 1 from the next edge.
- R10: Stop events that occur before the block has armed are ignored.
- R11: The three code fields are captured on the edge that first sees `cap_en` high. Later changes to them have no effect until `cap_en` has been low.
- R12: `st_trig` is set by the arming event. `st_trig` and `st_stopped` stay set while `cap_en` stays high, and both clear after `cap_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cap_en | input | 1 | Capture enable; a low level returns the block to off |
| cfg_start | input | 3 | Arm-event code |
| cfg_stop | input | 3 | Stop-event code |
| cfg_src | input | 3 | Source-bus selector |
| ev_watch | input | 1 | Watchpoint hit pulse |
| ev_match | input | 1 | Trace-match pulse |
| ev_perf | input | 1 | Performance-counter overflow pulse |
| ext_trig | input | 1 | Asynchronous external trigger level |
| ctx_cur | input | CTX_W | Current context identifier |
| ctx_prog | input | CTX_W | Programmed context identifier |
| src_data | input | 6*DW | Six candidate source buses, packed |
| src_valid | input | 6 | Per-source sample valid |
| wr_en | output | 1 | Trace memory write enable |
| wr_addr | output | AW | Trace memory write address |
| wr_data | output | DW | Trace memory write data |
| st_armed | output | 1 | Recording in progress |
| st_trig | output | 1 | Arming event has occurred |
| st_stopped | output | 1 | Recording has ended |
| st_err | output | 1 | Reserved source code latched |

## Verification
The assertions assume the event inputs are synchronous one-cycle pulses. They also assume `cap_en` is dropped only while no valid sample is presented. Otherwise a final write could share its cycle with the address reset. The stimulus drives every input one time unit after a rising edge and holds `ext_trig` steady for at least three cycles around each change, so the synchronizer always sees clean levels. Context identifiers are held at a level that is neutral for the active code, and are changed only to produce an event.

// File: rtl/trc_pkg.sv
package trc_pkg;

   localparam int TRC_CODE_W  = 3;
   localparam int TRC_NUM_SRC = 6;

   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_WAIT = 2'd1,
      PH_REC  = 2'd2,
      PH_END  = 2'd3
   } trc_phase_e;

   function automatic logic src_is_reserved(input logic [TRC_CODE_W-1:0] c);
      return (c[1:0] == 2'b11);
   endfunction

   function automatic int unsigned src_slot(input logic [TRC_CODE_W-1:0] c);
      return (c[2] ? 3 : 0) + int'(c[1:0]);
   endfunction

endpackage

// File: rtl/trc_trig_sync.sv
module trc_trig_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic rise,
   output logic fall
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("trc_trig_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], trig_in};
         last_q  <= chain_q[TOP];
      end
   end

   assign rise = chain_q[TOP] & ~last_q;
   assign fall = ~chain_q[TOP] & last_q;

   assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   assert_edge_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise, fall}));

endmodule

// File: rtl/trc_event_pick.sv
module trc_event_pick #(
   parameter bit CODE0_ALWAYS = 1'b1,
   parameter int CTX_W        = 8
) (
   input  logic [trc_pkg::TRC_CODE_W-1:0] code,
   input  logic                           full,
   input  logic                           ev_watch,
   input  logic                           ev_match,
   input  logic                           ev_perf,
   input  logic                           trig_rise,
   input  logic                           trig_fall,
   input  logic [CTX_W-1:0]               ctx_cur,
   input  logic [CTX_W-1:0]               ctx_prog,
   output logic                           hit
);

   generate
      if (CTX_W < 1) begin : g_bad_ctx
         $error("trc_event_pick: CTX_W must be positive");
      end
   endgenerate

   logic base_ev;
   logic ctx_same;

   generate
      if (CODE0_ALWAYS) begin : g_code0_now
         assign base_ev = 1'b1;
      end else begin : g_code0_full
         assign base_ev = full;
      end
   endgenerate

   assign ctx_same = (ctx_cur == ctx_prog);

   always_comb begin
      unique case (code)
         3'd0:    hit = base_ev;
         3'd1:    hit = ev_watch;
         3'd2:    hit = ev_match;
         3'd3:    hit = ev_perf;
         3'd4:    hit = trig_rise;
         3'd5:    hit = trig_fall;
         3'd6:    hit = ctx_same;
         default: hit = ~ctx_same;
      endcase
   end

endmodule

// File: rtl/trc_src_mux.sv
module trc_src_mux #(
   parameter int DW = 16
) (
   input  logic [trc_pkg::TRC_CODE_W-1:0]       sel,
   input  logic [trc_pkg::TRC_NUM_SRC*DW-1:0]   bus_flat,
   input  logic [trc_pkg::TRC_NUM_SRC-1:0]      bus_valid,
   output logic [DW-1:0]                        out_data,
   output logic                                 out_valid,
   output logic                                 reserved
);

   localparam int NSRC = trc_pkg::TRC_NUM_SRC;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("trc_src_mux: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] slot [NSRC];

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_slot
         assign slot[g] = bus_flat[g*DW +: DW];
      end
   endgenerate

   always_comb begin
      out_data  = '0;
      out_valid = 1'b0;
      reserved  = trc_pkg::src_is_reserved(sel);
      for (int i = 0; i < NSRC; i++) begin
         if (!reserved && trc_pkg::src_slot(sel) == i) begin
            out_data  = slot[i];
            out_valid = bus_valid[i];
         end
      end
   end

   assert_reserved_silent_R7: assert final (!(reserved && out_valid));

endmodule

// File: rtl/trc_capture_ctrl.sv
module trc_capture_ctrl #(
   parameter int DW          = 16,
   parameter int AW          = 3,
   parameter int CTX_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cap_en,
   input  logic [2:0]                           cfg_start,
   input  logic [2:0]                           cfg_stop,
   input  logic [2:0]                           cfg_src,
   input  logic                                 ev_watch,
   input  logic                                 ev_match,
   input  logic                                 ev_perf,
   input  logic                                 ext_trig,
   input  logic [CTX_W-1:0]                     ctx_cur,
   input  logic [CTX_W-1:0]                     ctx_prog,
   input  logic [trc_pkg::TRC_NUM_SRC*DW-1:0]   src_data,
   input  logic [trc_pkg::TRC_NUM_SRC-1:0]      src_valid,
   output logic                                 wr_en,
   output logic [AW-1:0]                        wr_addr,
   output logic [DW-1:0]                        wr_data,
   output logic                                 st_armed,
   output logic                                 st_trig,
   output logic                                 st_stopped,
   output logic                                 st_err
);

   import trc_pkg::*;

   localparam int DEPTH  = 1 << AW;
   localparam int FILL_W = AW + 1;
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

   generate
      if (AW < 1 || AW > 20) begin : g_bad_aw
         $error("trc_capture_ctrl: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("trc_capture_ctrl: DW must be positive");
      end
   endgenerate

   trc_phase_e              phase_q;
   logic [TRC_CODE_W-1:0]   start_q, stop_q, src_q;
   logic [AW-1:0]           ptr_q;
   logic [FILL_W-1:0]       fill_q;
   logic                    trig_q;

   logic rise, fall, full;
   logic start_hit, stop_hit;
   logic [DW-1:0] sel_data;
   logic sel_valid, sel_res;

   trc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (ext_trig),
      .rise    (rise),
      .fall    (fall)
   );

   assign full = (fill_q == FILL_MAX);

   trc_event_pick #(.CODE0_ALWAYS(1'b1), .CTX_W(CTX_W)) u_arm_pick (
      .code      (start_q),
      .full      (full),
      .ev_watch  (ev_watch),
      .ev_match  (ev_match),
      .ev_perf   (ev_perf),
      .trig_rise (rise),
      .trig_fall (fall),
      .ctx_cur   (ctx_cur),
      .ctx_prog  (ctx_prog),
      .hit       (start_hit)
   );

   trc_event_pick #(.CODE0_ALWAYS(1'b0), .CTX_W(CTX_W)) u_end_pick (
      .code      (stop_q),
      .full      (full),
      .ev_watch  (ev_watch),
      .ev_match  (ev_match),
      .ev_perf   (ev_perf),
      .trig_rise (rise),
      .trig_fall (fall),
      .ctx_cur   (ctx_cur),
      .ctx_prog  (ctx_prog),
      .hit       (stop_hit)
   );

   trc_src_mux #(.DW(DW)) u_mux (
      .sel       (src_q),
      .bus_flat  (src_data),
      .bus_valid (src_valid),
      .out_data  (sel_data),
      .out_valid (sel_valid),
      .reserved  (sel_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         start_q <= '0;
         stop_q  <= '0;
         src_q   <= '0;
         trig_q  <= 1'b0;
      end else if (!cap_en) begin
         phase_q <= PH_OFF;
         trig_q  <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_OFF: begin
               start_q <= cfg_start;
               stop_q  <= cfg_stop;
               src_q   <= cfg_src;
               phase_q <= PH_WAIT;
            end
            PH_WAIT: begin
               if (start_hit) begin
                  phase_q <= PH_REC;
                  trig_q  <= 1'b1;
               end
            end
            PH_REC: begin
               if (stop_hit) phase_q <= PH_END;
            end
            default: phase_q <= PH_END;
         endcase
      end
   end

   assign wr_en = (phase_q == PH_REC) && sel_valid && !sel_res && !stop_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         fill_q <= '0;
      end else if (!cap_en) begin
         ptr_q  <= '0;
         fill_q <= '0;
      end else if (wr_en) begin
         ptr_q <= ptr_q + 1'b1;
         if (!full) fill_q <= fill_q + 1'b1;
      end
   end

   assign wr_addr    = ptr_q;
   assign wr_data    = sel_data;
   assign st_armed   = (phase_q == PH_REC);
   assign st_trig    = trig_q;
   assign st_stopped = (phase_q == PH_END);
   assign st_err     = (phase_q != PH_OFF) && src_is_reserved(src_q);

   assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> (!wr_en && !st_armed && !st_trig && !st_stopped && !st_err));
   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cap_en) |=> (wr_addr == $past(wr_addr) + 1'b1));
   assert_err_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st_err |-> !wr_en);
   assert_full_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q == 3'd0 && full) |-> !wr_en);
   assert_stop_after_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_stopped |-> st_trig);
   assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_OFF && cap_en) |=> $stable(start_q) && $stable(stop_q) && $stable(src_q));
   assert_stop_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_stopped && cap_en) |=> st_stopped);

endmodule

// File: tb/trc_capture_ctrl_tb_top.sv
module trc_capture_ctrl_tb_top;

   localparam int DW = 16;
   localparam int AW = 3;
   localparam int CW = 8;
   localparam int DEPTH = 1 << AW;
   localparam int NS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_en = 1'b0;
   logic [2:0] cfg_start = '0, cfg_stop = '0, cfg_src = '0;
   logic ev_watch = 1'b0, ev_match = 1'b0, ev_perf = 1'b0, ext_trig = 1'b0;
   logic [CW-1:0] ctx_cur = 8'h11, ctx_prog = 8'h3C;
   logic [NS*DW-1:0] src_data = '0;
   logic [NS-1:0] src_valid = '0;
   logic wr_en, st_armed, st_trig, st_stopped, st_err;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   always #4 clk = ~clk;

   trc_capture_ctrl #(.DW(DW), .AW(AW), .CTX_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
      .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_src(cfg_src),
      .ev_watch(ev_watch), .ev_match(ev_match), .ev_perf(ev_perf),
      .ext_trig(ext_trig), .ctx_cur(ctx_cur), .ctx_prog(ctx_prog),
      .src_data(src_data), .src_valid(src_valid),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .st_armed(st_armed), .st_trig(st_trig), .st_stopped(st_stopped), .st_err(st_err)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int exp_ptr = 0;
   logic [2:0] cur_src = '0;
   logic [AW+DW-1:0] sb_q [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int slot_of(input logic [2:0] c);
      return (c[2] ? 3 : 0) + int'(c[1:0]);
   endfunction

   // monitor: pop and compare every write
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R6 unexpected write", int'({wr_addr, wr_data}), -1);
         end else begin
            logic [AW+DW-1:0] item;
            item = sb_q.pop_front();
            chk({wr_addr, wr_data} == item, "R6 write addr/data",
                int'({wr_addr, wr_data}), int'(item));
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // driver: present one sample on all buses, push the expected write
   task automatic sample(input logic [DW-1:0] base, input bit expw, input bit valid = 1'b1);
      logic [DW-1:0] v;
      for (int i = 0; i < NS; i++) begin
         src_data[i*DW +: DW] = base + DW'(i * 16'h1000);
      end
      src_valid = valid ? '1 : '0;
      if (expw) begin
         v = base + DW'(slot_of(cur_src) * 16'h1000);
         sb_q.push_back({AW'(exp_ptr), v});
         exp_ptr++;
      end
      tick();
      src_valid = '0;
   endtask

   task automatic drain_chk(input string req);
      @(negedge clk);
      chk(sb_q.size() == 0, req, sb_q.size(), 0);
      sb_q.delete();
   endtask

   task automatic idle_for(input logic [2:0] c);
      ext_trig = (c == 3'd5);
      ctx_cur  = (c == 3'd7) ? ctx_prog : (ctx_prog ^ 8'h5A);
   endtask

   task automatic start(input logic [2:0] st, input logic [2:0] sp, input logic [2:0] src);
      cap_en = 1'b0;
      cfg_start = st; cfg_stop = sp; cfg_src = src;
      idle_for(st);
      repeat (4) tick();
      cap_en = 1'b1;
      exp_ptr = 0;
      cur_src = src;
      tick();
   endtask

   task automatic fire(input logic [2:0] c);
      case (c)
         3'd1: begin ev_watch = 1'b1; tick(); ev_watch = 1'b0; end
         3'd2: begin ev_match = 1'b1; tick(); ev_match = 1'b0; end
         3'd3: begin ev_perf = 1'b1; tick(); ev_perf = 1'b0; end
         3'd4: begin ext_trig = 1'b1; repeat (3) tick(); ext_trig = 1'b0; repeat (3) tick(); end
         3'd5: begin ext_trig = 1'b0; repeat (3) tick(); ext_trig = 1'b1; repeat (3) tick(); end
         3'd6: begin ctx_cur = ctx_prog; tick(); ctx_cur = ctx_prog ^ 8'h5A; end
         default: begin ctx_cur = ctx_prog ^ 8'h77; tick(); ctx_cur = ctx_prog; end
      endcase
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({wr_en, st_armed, st_trig, st_stopped, st_err} == 5'b0, "R1 reset outputs",
          int'({wr_en, st_armed, st_trig, st_stopped, st_err}), 0);
      chk(wr_addr == '0, "R1 reset addr", int'(wr_addr), 0);
      rst_n = 1'b1;
      tick();

      // R2 immediate arm, R6 selection, R9 stop cycle writes nothing
      start(3'd0, 3'd1, 3'b000);
      @(negedge clk);
      chk(!st_armed, "R2 not yet armed", int'(st_armed), 0);
      tick();
      @(negedge clk);
      chk(st_armed && st_trig, "R2 armed at once", int'({st_armed, st_trig}), 3);
      sample(16'h0100, 1'b1);
      sample(16'h0200, 1'b1);
      sample(16'h0300, 1'b0, 1'b0);
      sample(16'h0400, 1'b1);
      ev_watch = 1'b1;
      sample(16'h0500, 1'b0);
      ev_watch = 1'b0;
      @(negedge clk);
      chk(st_stopped && !st_armed, "R9 stopped by watch", int'({st_stopped, st_armed}), 2);
      sample(16'h0600, 1'b0);
      repeat (3) tick();
      @(negedge clk);
      chk(st_stopped && st_trig, "R12 stopped and trig hold", int'({st_stopped, st_trig}), 3);
      drain_chk("R9 no write after stop");
      cap_en = 1'b0;
      tick();
      @(negedge clk);
      chk({st_trig, st_stopped, st_armed} == 3'b0, "R12 cleared by disable",
          int'({st_trig, st_stopped, st_armed}), 0);
      chk(wr_addr == '0, "R1 addr restarts", int'(wr_addr), 0);

      // every arm/stop code 1..7
      for (int c = 1; c < 8; c++) begin
         string tg;
         tg = (c <= 3) ? "R3" : (c <= 5) ? "R4" : "R5";
         start(3'(c), 3'(c), 3'b001);
         repeat (3) tick();
         @(negedge clk);
         chk(!st_armed, {tg, " not armed without event"}, int'(st_armed), 0);
         fire(3'(c));
         @(negedge clk);
         chk(st_armed && st_trig && !st_stopped, {tg, " armed by event"},
             int'({st_armed, st_trig, st_stopped}), 6);
         sample(16'h0A00 + 16'(c), 1'b1);
         fire(3'(c));
         @(negedge clk);
         chk(st_stopped, "R9 stopped by same event code", int'(st_stopped), 1);
         sample(16'h0B00, 1'b0);
         drain_chk("R9 sequence writes");
      end

      // R10 stop events before arming ignored
      start(3'd2, 3'd1, 3'b010);
      fire(3'd1);
      @(negedge clk);
      chk(!st_stopped && !st_armed, "R10 early stop ignored", int'({st_stopped, st_armed}), 0);
      fire(3'd2);
      @(negedge clk);
      chk(st_armed, "R10 arms after ignored stop", int'(st_armed), 1);
      sample(16'h0C00, 1'b1);
      fire(3'd1);
      @(negedge clk);
      chk(st_stopped, "R10 stop honoured after trigger", int'(st_stopped), 1);
      drain_chk("R10 writes");

      // R8 stop on full, source 110
      start(3'd0, 3'd0, 3'b110);
      tick();
      for (int k = 0; k < DEPTH; k++) sample(16'h0010 + 16'(k), 1'b1);
      sample(16'h00FF, 1'b0);
      @(negedge clk);
      chk(st_stopped, "R8 stopped on full", int'(st_stopped), 1);
      sample(16'h00EE, 1'b0);
      drain_chk("R8 exactly DEPTH writes");

      // R6 wrap-around, source 100
      start(3'd0, 3'd1, 3'b100);
      tick();
      for (int k = 0; k < DEPTH + 2; k++) sample(16'h0020 + 16'(k), 1'b1);
      sample(16'h0077, 1'b0, 1'b0);
      @(negedge clk);
      chk(st_armed && !st_stopped, "R6 still recording after wrap",
          int'({st_armed, st_stopped}), 2);
      drain_chk("R6 wrap writes");

      // R7 reserved sources
      for (int r = 0; r < 2; r++) begin
         start(3'd0, 3'd1, r == 0 ? 3'b011 : 3'b111);
         tick();
         @(negedge clk);
         chk(st_err, "R7 error flag", int'(st_err), 1);
         sample(16'h0555, 1'b0);
         sample(16'h0666, 1'b0);
         drain_chk("R7 nothing written");
      end
      cap_en = 1'b0;
      tick();
      @(negedge clk);
      chk(!st_err, "R1 error cleared when off", int'(st_err), 0);

      // R11 fields latched at enable
      start(3'd1, 3'd1, 3'b000);
      cfg_start = 3'd0;
      cfg_src   = 3'b101;
      cfg_stop  = 3'd2;
      repeat (3) tick();
      @(negedge clk);
      chk(!st_armed, "R11 arm code change ignored", int'(st_armed), 0);
      fire(3'd1);
      @(negedge clk);
      chk(st_armed, "R11 arms on latched code", int'(st_armed), 1);
      sample(16'h0D00, 1'b1);
      fire(3'd2);
      @(negedge clk);
      chk(!st_stopped, "R11 stop code change ignored", int'(st_stopped), 0);
      drain_chk("R11 latched source used");
      cap_en = 1'b0;
      tick();

      summary();
      $finish;
   end

endmodule